// File: doc/BRIEF.md
# Scratchpad Write CRC-16 Generator

This block sits on the slave side of a serial memory link and produces the CRC-16 that a scratchpad write transaction returns. A start pulse clears the CRC register and opens a transaction. The block then takes one byte per accepted `in_valid` cycle, in this order: a command code, a low address byte, a high address byte, and then the data bytes. Every byte in that stream, addresses included, goes into the CRC.

The low 5 bits of the low address byte give the starting scratchpad offset. The offset steps up by one for each data byte. When the byte written at offset 31 is accepted, the block freezes the CRC. It then presents the bit-inverted CRC as two consecutive output bytes, low byte first.

A transaction that never reaches offset 31 returns nothing. Data bytes that arrive after offset 31 are discarded. An abort input drops the transaction at any point, including while the result bytes are being sent.

Top module: `spw_crc16_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0.
- R2: The CRC starts from 0x0000 at each `start`. Each byte is folded in least significant bit first, using the reflected feedback constant 0xA001 (polynomial x^16+x^15+x^2+1).
- R3: The CRC covers, in order, the command byte, the low address byte, the high address byte and each accepted data byte.
- R4: When the data byte at offset 31 is accepted at a clock edge, `out_valid` is 1 for exactly the next two cycles. `out_data` carries bits 7:0 of the inverted CRC in the first of these cycles and bits 15:8 in the second.
- R5: The starting offset is `in_data[4:0]` of the low address byte; its bits 7:5 are ignored. If a new `start` arrives before the byte at offset 31 has been written, that transaction produces no output.
- R6: Bytes accepted after offset 31 has been written, including during the two result cycles, do not change the emitted CRC and produce no further output.
- R7: `abort` returns the block to idle, clears the CRC register and ends any result emission in the next cycle. A transaction that is aborted produces no output.
- R8: With no transaction open (after reset or after `abort`), bytes presented on `in_valid` are ignored.
- R9: Cycles with `in_valid` low do not advance the byte order, the offset or the CRC.
- R10: A byte presented in the same cycle as `start` is not taken. `abort` takes priority over `start` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the CRC and opens a transaction |
| abort | input | 1 | Drops the transaction and all state |
| in_valid | input | 1 | Byte on `in_data` is offered this cycle |
| in_data | input | 8 | Command, address or data byte |
| out_valid | output | 1 | A CRC result byte is on `out_data` |
| out_data | output | 8 | Inverted CRC byte, low byte first |

## Verification
The bench sweeps starting offsets from 31 (a single data byte) down to 0 (32 bytes). It also sets the upper address bits, so a design that used the whole address byte as the offset would emit at the wrong time or not at all. Random idle gaps between bytes catch a design that advances on cycles with `in_valid` low. A stray byte driven during the first result cycle catches a design that keeps folding data in after offset 31. Collisions of `start` with a byte, `abort` with `start`, and `abort` during emission check the priority order: a wrong order would give a shifted CRC, or a result byte that should have been suppressed.

// File: rtl/spw_crc_pkg.sv
package spw_crc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_CMD    = 3'd1,
      PH_ADR_LO = 3'd2,
      PH_ADR_HI = 3'd3,
      PH_DATA   = 3'd4,
      PH_DONE   = 3'd5
   } phase_e;

endpackage

// File: rtl/spw_crc_step.sv
// One-byte CRC update. LSB_FIRST picks between the reflected and the
// straight shift variant; POLY is always given in straight form.
module spw_crc_step #(
   parameter int                 CRC_W     = 16,
   parameter int                 DATA_W    = 8,
   parameter logic [CRC_W-1:0]   POLY      = 16'h8005,
   parameter bit                 LSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [CRC_W-1:0]  crc_o
);

   function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
      return r;
   endfunction

   localparam logic [CRC_W-1:0] POLY_R = mirror(POLY);

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            logic [CRC_W-1:0] c;
            c = crc_i ^ {{(CRC_W-DATA_W){1'b0}}, byte_i};
            for (int b = 0; b < DATA_W; b++)
               c = c[0] ? ((c >> 1) ^ POLY_R) : (c >> 1);
            crc_o = c;
         end
      end else begin : g_msb
         always_comb begin
            logic [CRC_W-1:0] c;
            c = crc_i ^ {byte_i, {(CRC_W-DATA_W){1'b0}}};
            for (int b = 0; b < DATA_W; b++)
               c = c[CRC_W-1] ? ((c << 1) ^ POLY) : (c << 1);
            crc_o = c;
         end
      end
   endgenerate

endmodule

// File: rtl/spw_crc_seq.sv
// Tracks which byte of the transaction comes next and the scratchpad offset.
module spw_crc_seq
   import spw_crc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OFFSET_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output phase_e            phase_q,
   output logic              take,
   output logic              fire
);

   localparam logic [OFFSET_W-1:0] LAST_OFF = '1;

   logic [OFFSET_W-1:0] off_q;
   logic                open_ph;

   always_comb begin
      open_ph = (phase_q == PH_CMD) || (phase_q == PH_ADR_LO) ||
                (phase_q == PH_ADR_HI) || (phase_q == PH_DATA);
      take    = in_valid && !start && !abort && open_ph;
      fire    = take && (phase_q == PH_DATA) && (off_q == LAST_OFF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         off_q   <= '0;
      end else if (abort) begin
         phase_q <= PH_IDLE;
         off_q   <= '0;
      end else if (start) begin
         phase_q <= PH_CMD;
         off_q   <= '0;
      end else if (take) begin
         unique case (phase_q)
            PH_CMD:    phase_q <= PH_ADR_LO;
            PH_ADR_LO: begin
               off_q   <= in_data[OFFSET_W-1:0];
               phase_q <= PH_ADR_HI;
            end
            PH_ADR_HI: phase_q <= PH_DATA;
            PH_DATA: begin
               if (off_q == LAST_OFF) phase_q <= PH_DONE;
               else                   off_q   <= off_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/spw_crc_tx.sv
// Sends the inverted CRC as CRC_W/DATA_W bytes, least significant first.
module spw_crc_tx #(
   parameter int CRC_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              fire,
   input  logic [CRC_W-1:0]  crc,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   localparam int NBYTES = CRC_W / DATA_W;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic [CRC_W-1:0] crc_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (clear) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (fire) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (idx_q == IDX_LAST) busy_q <= 1'b0;
         else                   idx_q  <= idx_q + 1'b1;
      end
   end

   assign crc_inv   = ~crc;
   assign out_valid = busy_q;
   assign out_data  = crc_inv[int'(idx_q)*DATA_W +: DATA_W];

endmodule

// File: rtl/spw_crc16_gen.sv
module spw_crc16_gen
   import spw_crc_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               CRC_W     = 16,
   parameter int               OFFSET_W  = 5,
   parameter logic [CRC_W-1:0] POLY      = 16'h8005,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   generate
      if (CRC_W % DATA_W != 0) begin : g_bad_ratio
         $error("CRC_W must be a multiple of DATA_W");
      end
      if (OFFSET_W < 1 || OFFSET_W > DATA_W) begin : g_bad_off
         $error("OFFSET_W must lie in 1..DATA_W");
      end
      if (CRC_W < DATA_W) begin : g_bad_crc
         $error("CRC_W must be at least DATA_W");
      end
   endgenerate

   phase_e           phase_q;
   logic             take;
   logic             fire;
   logic             clear;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nx;

   assign clear = start | abort;

   spw_crc_seq #(
      .DATA_W   (DATA_W),
      .OFFSET_W (OFFSET_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (abort),
      .in_valid (in_valid),
      .in_data  (in_data),
      .phase_q  (phase_q),
      .take     (take),
      .fire     (fire)
   );

   spw_crc_step #(
      .CRC_W     (CRC_W),
      .DATA_W    (DATA_W),
      .POLY      (POLY),
      .LSB_FIRST (LSB_FIRST)
   ) u_step (
      .crc_i  (crc_q),
      .byte_i (in_data),
      .crc_o  (crc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clear) crc_q <= '0;
      else if (take)  crc_q <= crc_nx;
   end

   spw_crc_tx #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .fire      (fire),
      .crc       (crc_q),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: rtl/spw_crc_chk.sv
module spw_crc_chk
   import spw_crc_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   start,
   input logic   abort,
   input logic   out_valid,
   input phase_e phase
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !out_valid);                                                  // R1

   AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) && !start && !abort |=> out_valid);                     // R4

   AST_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(out_valid) |=> !out_valid);                           // R4

   AST_EMIT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> phase == PH_DONE);                                         // R5

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !out_valid);                                                   // R7

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> phase == PH_IDLE);                                             // R7

   AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      start && !abort |=> !out_valid && phase == PH_CMD);                      // R10

endmodule

bind spw_crc16_gen spw_crc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .abort     (abort),
   .out_valid (out_valid),
   .phase     (phase_q)
);

// File: tb/tb_spw_crc16_gen.sv
`timescale 1ns/1ps
module tb_spw_crc16_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       abort = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid;
   logic [7:0] out_data;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   always #2.5 clk = ~clk;

   spw_crc16_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   always @(negedge clk) if (rst_n && out_valid) pulses++;

   function automatic logic [15:0] upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {8'h00, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
      return r;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      in_valid = 1'b1; in_data = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_start(input bit collide);
      start = 1'b1;
      if (collide) begin in_valid = 1'b1; in_data = 8'hA5; end
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
   endtask

   task automatic gap(input bit en);
      if (en) repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   // Full transaction ending at offset 31; checks the two result bytes.
   task automatic run_txn(input logic [7:0] cmd, input logic [7:0] ta1,
                          input logic [7:0] ta2, input bit gaps,
                          input bit extra, input bit collide, input string tag);
      logic [15:0] crc;
      int          n;
      pulse_start(collide);                       // R10: colliding byte not taken
      crc = 16'h0000;                             // R2
      crc = upd(crc, cmd); send(cmd); gap(gaps);  // R3 order
      crc = upd(crc, ta1); send(ta1); gap(gaps);
      crc = upd(crc, ta2); send(ta2); gap(gaps);
      n = 32 - int'(ta1[4:0]);                    // R5 offset from low 5 bits
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = 8'($urandom);
         crc = upd(crc, d);
         if (k < n - 1) begin
            send(d); gap(gaps);                   // R9 gaps
         end else begin
            in_valid = 1'b1; in_data = d;
            @(negedge clk);
            if (extra) begin in_valid = 1'b1; in_data = 8'($urandom); end
            else in_valid = 1'b0;
            check({tag, " R4 lo valid"}, {15'd0, out_valid}, 16'd1);
            check({tag, " R2/R3/R4 lo byte"}, {8'd0, out_data}, {8'd0, ~crc[7:0]});
            @(negedge clk);
            in_valid = 1'b0;
            check({tag, " R4 hi valid"}, {15'd0, out_valid}, 16'd1);
            check({tag, " R6/R4 hi byte"}, {8'd0, out_data}, {8'd0, ~crc[15:8]});
            @(negedge clk);
            check({tag, " R4/R6 ends"}, {15'd0, out_valid}, 16'd0);
         end
      end
   endtask

   initial begin
      #(150000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int p0;
      void'($urandom(32'h5EED_0C2C));
      repeat (4) @(negedge clk);
      check("R1 reset", {15'd0, out_valid}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {15'd0, out_valid}, 16'd0);

      // R8: bytes with no transaction open are ignored
      p0 = pulses;
      for (int i = 0; i < 40; i++) send(8'hFF);
      check("R8 idle no output", 16'(pulses - p0), 16'd0);
      run_txn(8'h0F, 8'h00, 8'h00, 0, 0, 0, "R8 after idle");

      // R5 boundary offsets
      run_txn(8'h0F, 8'h1F, 8'h12, 0, 0, 0, "R5 single byte");
      run_txn(8'h0F, 8'hE0, 8'h01, 0, 0, 0, "R5 high bits ignored");
      run_txn(8'h0F, 8'h3E, 8'h00, 1, 0, 0, "R9 gaps");

      // R6 extra byte during result
      run_txn(8'h0F, 8'h1C, 8'h00, 0, 1, 0, "R6 extra");

      // R10 byte collides with start
      run_txn(8'h0F, 8'h18, 8'h00, 0, 0, 1, "R10 collide");

      // R5 incomplete transaction then restart: no output
      p0 = pulses;
      pulse_start(0);
      send(8'h0F); send(8'h05); send(8'h00);
      for (int i = 0; i < 10; i++) send(8'($urandom));
      pulse_start(0);
      check("R5 incomplete silent", 16'(pulses - p0), 16'd0);

      // R7 abort mid data, then the last data byte offered
      p0 = pulses;
      pulse_start(0);
      send(8'h0F); send(8'h1E); send(8'h00); send(8'h11);
      abort = 1'b1; @(negedge clk); abort = 1'b0;
      send(8'h22); send(8'h33);
      repeat (3) @(negedge clk);
      check("R7 aborted silent", 16'(pulses - p0), 16'd0);

      // R7 abort during result emission
      pulse_start(0);
      send(8'h0F); send(8'h1F); send(8'h00);
      in_valid = 1'b1; in_data = 8'h44;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 lo present", {15'd0, out_valid}, 16'd1);
      abort = 1'b1; @(negedge clk); abort = 1'b0;
      check("R7 emission cut", {15'd0, out_valid}, 16'd0);

      // R10 abort wins over start
      p0 = pulses;
      abort = 1'b1; start = 1'b1; @(negedge clk); abort = 1'b0; start = 1'b0;
      send(8'h0F); send(8'h1F); send(8'h00); send(8'h55);
      repeat (3) @(negedge clk);
      check("R10 abort over start", 16'(pulses - p0), 16'd0);
      run_txn(8'h0F, 8'h00, 8'h00, 0, 0, 0, "R7 recovery");

      // Random transactions
      for (int t = 0; t < 40; t++)
         run_txn(8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "R2/R3 random");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule